// File: doc/BRIEF.md
# I2S Slave Microphone Data Transmitter

This block places one 24-bit two's-complement audio word per stereo frame onto a serial data wire in I2S format. The bit clock and word select come from an external master. The block samples both of them with its own system clock, so it works as a slave and never generates a clock. A channel-select input picks the half of the frame that the block answers in. With select low it transmits while word select is low, which is the half that starts at a word-select falling edge. With select high it transmits while word select is high, which is the half that starts at a rising edge.

The serial output comes with an output-enable meant for a tri-state pad. Two instances set to opposite channels can then share one data wire. Each instance drives the wire only for the 24 bit slots of its own word and releases it at once after the least significant bit. The word is taken from the sample input when the block's half-frame begins. It is then held until the next half-frame, so the producer may change the input while the word is being sent.

The block expects 32 bit-clock periods per half-frame. If word select toggles early, the block drops the current word where it stands and starts a new half-frame from that edge.

Top module: `i2s_mic_tx`

## Requirements
- R1: After reset, sd_oe_o and sd_o are low and stay low until a word-select transition has been seen.
- R2: With chan_right_i low, the block drives the line only in a half-frame where ws_i is low, which is a half-frame that starts at a ws_i falling edge.
- R3: With chan_right_i high, the block drives the line only in a half-frame where ws_i is high, which is a half-frame that starts at a ws_i rising edge.
- R4: Bit slot k of a half-frame is the k-th sck_i falling edge after the sck_i rising edge at which the new ws_i level is first seen. The word is driven MSB first, in slots 1 to 24, with bit 23 in slot 1 and bit 0 in slot 24. The receiver samples each bit on the sck_i rising edge that follows.
- R5: sd_oe_o falls on the sck_i falling edge right after the LSB slot, and slots 25 to 32 are left undriven.
- R6: sample_i is captured when the block's own half-frame begins. Changes on sample_i during the half-frame have no effect on the bits sent.
- R7: If a ws_i edge arrives before 32 bit periods have passed, the block starts a fresh half-frame from that edge. Bits of the cut word go out only up to that edge, and the enable drops on the next falling edge unless the new half-frame belongs to this block.
- R8: Two instances set to opposite channels on the same sck_i and ws_i never assert sd_oe_o together.
- R9: sd_o is low whenever sd_oe_o is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples sck_i and ws_i |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Bit clock from the I2S master |
| ws_i | input | 1 | Word select from the I2S master |
| chan_right_i | input | 1 | 0: transmit in the ws-low half, 1: transmit in the ws-high half |
| sample_i | input | 24 | Two's-complement sample for the next owned half-frame |
| sd_o | output | 1 | Serial data toward the pad |
| sd_oe_o | output | 1 | Pad output enable, high only while a word bit is driven |

## Verification
A slot counter that is off by one moves the whole word by one bit. This shows up on the first sampled rising edge of the half-frame, as an MSB in slot 0 or slot 2, or as a 23- or 25-bit run. A wrong ownership flag makes the enable appear in the other instance's half. On the shared wire the two enables then overlap within one bit period of the word-select edge. A capture register that follows the input instead of holding its value corrupts the bits sent after the producer changes sample_i, four bit periods into the word. Faulty resynchronisation leaves the enable high past an early word-select edge, and the two instances then collide on the next falling edge.

// File: rtl/i2s_mic_pkg.sv
`timescale 1ns/1ps
package i2s_mic_pkg;

  typedef enum logic {
    CH_LEFT  = 1'b0,
    CH_RIGHT = 1'b1
  } chan_e;

  // The half-frame belongs to this block when the word-select level
  // matches the chosen channel: low for left, high for right.
  function automatic logic half_owned(logic ws_lvl, chan_e ch);
    return (ch == CH_RIGHT) ? ws_lvl : !ws_lvl;
  endfunction

endpackage

// File: rtl/i2s_edge_sync.sv
`timescale 1ns/1ps
module i2s_edge_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);

  // chain[STAGES-1] is the synchronised level; chain[STAGES] is the same
  // level one clock later, kept for edge detection.
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {(STAGES + 1){RST_VAL}};
    else        chain <= {chain[STAGES-1:0], d_i};
  end

  assign lvl_o  = chain[STAGES-1];
  assign rise_o = chain[STAGES-1] & ~chain[STAGES];
  assign fall_o = ~chain[STAGES-1] & chain[STAGES];

endmodule

// File: rtl/i2s_slot_ctrl.sv
`timescale 1ns/1ps
module i2s_slot_ctrl
  import i2s_mic_pkg::*;
#(
  parameter int DATA_W     = 24,
  parameter int HALF_SLOTS = 32,
  localparam int SW = $clog2(HALF_SLOTS + 1),
  localparam int IW = $clog2(DATA_W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sck_rise_i,
  input  logic          sck_fall_i,
  input  logic          ws_lvl_i,
  input  chan_e         chan_i,
  output logic          ws_edge_o,
  output logic          load_o,
  output logic          tick_o,
  output logic          win_o,
  output logic [IW-1:0] bit_idx_o,
  output logic          half_active_o,
  output logic [SW-1:0] slot_o
);

  logic          ws_ref;
  logic          half_active;
  logic [SW-1:0] slot;
  logic [SW-1:0] slot_nxt;

  // Slot 1..DATA_W carries a data bit.
  function automatic logic in_window(logic [SW-1:0] s);
    return (s != '0) && (s <= SW'(DATA_W));
  endfunction

  // Slot 1 carries the MSB, slot DATA_W the LSB.
  function automatic logic [IW-1:0] bit_of(logic [SW-1:0] s);
    return in_window(s) ? IW'(DATA_W - int'(s)) : '0;
  endfunction

  // Word select is read on bit-clock rising edges, as a receiver would.
  assign ws_edge_o = sck_rise_i && (ws_lvl_i != ws_ref);
  assign load_o    = ws_edge_o && half_owned(ws_lvl_i, chan_i);
  assign slot_nxt  = (slot == SW'(HALF_SLOTS)) ? slot : slot + SW'(1);
  assign tick_o    = sck_fall_i;
  assign win_o     = half_active && in_window(slot_nxt);
  assign bit_idx_o = bit_of(slot_nxt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_ref      <= 1'b1;
      half_active <= 1'b0;
      slot        <= SW'(HALF_SLOTS);
    end else begin
      if (sck_rise_i) ws_ref <= ws_lvl_i;
      if (ws_edge_o) begin
        slot        <= '0;
        half_active <= half_owned(ws_lvl_i, chan_i);
      end else if (sck_fall_i) begin
        slot <= slot_nxt;
      end
    end
  end

  assign half_active_o = half_active;
  assign slot_o        = slot;

endmodule

// File: rtl/i2s_tx_shift.sv
`timescale 1ns/1ps
module i2s_tx_shift #(
  parameter int DATA_W = 24,
  localparam int IW = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] sample_i,
  input  logic              tick_i,
  input  logic              win_i,
  input  logic [IW-1:0]     bit_idx_i,
  output logic              sd_o,
  output logic              sd_oe_o
);

  logic [DATA_W-1:0] word;
  logic              next_bit;

  assign next_bit = win_i ? word[bit_idx_i] : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word <= '0;
    else if (load_i) word <= sample_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sd_o    <= 1'b0;
      sd_oe_o <= 1'b0;
    end else if (tick_i) begin
      sd_o    <= next_bit;
      sd_oe_o <= win_i;
    end
  end

  AST_QUIET_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_oe_o |-> !sd_o); // R9
  AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(word)); // R6

endmodule

// File: rtl/i2s_mic_tx.sv
`timescale 1ns/1ps
module i2s_mic_tx
  import i2s_mic_pkg::*;
#(
  parameter int DATA_W      = 24,
  parameter int HALF_SLOTS  = 32,
  parameter int SYNC_STAGES = 2,
  localparam int SW = $clog2(HALF_SLOTS + 1),
  localparam int IW = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_i,
  input  logic              ws_i,
  input  logic              chan_right_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              sd_o,
  output logic              sd_oe_o
);

  logic          sck_lvl, sck_rise, sck_fall;
  logic          ws_lvl, ws_rise_unused, ws_fall_unused;
  logic          ws_edge, load, tick, win, half_active;
  logic [IW-1:0] bit_idx;
  logic [SW-1:0] slot;
  chan_e         chan;

  assign chan = chan_right_i ? CH_RIGHT : CH_LEFT;

  i2s_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sck_sync (
    .clk(clk), .rst_n(rst_n), .d_i(sck_i),
    .lvl_o(sck_lvl), .rise_o(sck_rise), .fall_o(sck_fall)
  );

  i2s_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ws_sync (
    .clk(clk), .rst_n(rst_n), .d_i(ws_i),
    .lvl_o(ws_lvl), .rise_o(ws_rise_unused), .fall_o(ws_fall_unused)
  );

  i2s_slot_ctrl #(.DATA_W(DATA_W), .HALF_SLOTS(HALF_SLOTS)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .sck_rise_i(sck_rise), .sck_fall_i(sck_fall),
    .ws_lvl_i(ws_lvl), .chan_i(chan),
    .ws_edge_o(ws_edge), .load_o(load), .tick_o(tick), .win_o(win),
    .bit_idx_o(bit_idx), .half_active_o(half_active), .slot_o(slot)
  );

  i2s_tx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .load_i(load), .sample_i(sample_i),
    .tick_i(tick), .win_i(win), .bit_idx_i(bit_idx),
    .sd_o(sd_o), .sd_oe_o(sd_oe_o)
  );

  // The enable may outlive ownership only in the gap between an early
  // word-select edge (slot cleared) and the next bit-clock falling edge.
  AST_OE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    sd_oe_o |-> (half_active || slot == '0)); // R2 R3
  AST_MSB_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sd_oe_o) |-> (slot == SW'(1))); // R4
  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sd_oe_o) |-> (slot == SW'(DATA_W + 1) || !half_active)); // R5 R7
  AST_EDGE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    ws_edge |-> (sck_lvl && !sck_fall)); // R7

endmodule

// File: tb/tb_i2s_mic_tx.sv
`timescale 1ns/1ps
module tb_i2s_mic_tx;
  localparam int DW = 24;

  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, ws = 1'b1, sck_run = 1'b0;
  logic [DW-1:0] smp_l = '0, smp_r = '0;
  logic sd_l, oe_l, sd_r, oe_r;
  int total = 0, bad = 0, k = 0;
  bit done = 0;

  typedef struct packed {
    logic [DW-1:0] data;
    logic [5:0]    nbits;
    logic          src;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  i2s_mic_tx dut (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .ws_i(ws), .chan_right_i(1'b0),
    .sample_i(smp_l), .sd_o(sd_l), .sd_oe_o(oe_l)
  );
  i2s_mic_tx dut_r (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .ws_i(ws), .chan_right_i(1'b1),
    .sample_i(smp_r), .sd_o(sd_r), .sd_oe_o(oe_r)
  );

  task automatic chk(bit ok, string req, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] val(int n);
    logic [31:0] t;
    t = 32'h9E3779B9 * (n + 3);
    return t[31:8];
  endfunction

  initial begin
    wait (sck_run);
    forever #64 sck = ~sck;
  end

  // Monitor: bits on the shared wire at each bit-clock rising edge.
  int s_cnt = 40, nb = 0, cur = -1, prv = -1;
  logic ws_seen = 1'b1;
  logic [DW-1:0] acc = '0;

  task automatic close_word();
    exp_t e;
    if (q.size() == 0) begin
      chk(1'b0, "R2 R3 unexpected word", acc, 0);
    end else begin
      e = q.pop_front();
      chk(nb == int'(e.nbits), "R5/R7 bit count", nb, e.nbits);
      chk(acc == (e.data >> (DW - int'(e.nbits))), "R4/R6 word bits",
          acc, e.data >> (DW - int'(e.nbits)));
      chk(prv == int'(e.src), "R2 R3 driving channel", prv, e.src);
      chk(s_cnt == ((int'(e.nbits) == DW) ? DW + 1 : 1), "R5/R7 release slot",
          s_cnt, (int'(e.nbits) == DW) ? DW + 1 : 1);
    end
    acc = '0;
    nb  = 0;
  endtask

  initial begin
    forever begin
      @(posedge sck);
      #1;
      if (ws != ws_seen) s_cnt = 0;
      else if (s_cnt < 40) s_cnt++;
      ws_seen = ws;
      chk(!(oe_l && oe_r), "R8 shared line contention", {oe_l, oe_r}, 0);
      chk(oe_l || !sd_l, "R9 left idle data", sd_l, 0);
      chk(oe_r || !sd_r, "R9 right idle data", sd_r, 0);
      cur = oe_l ? 0 : (oe_r ? 1 : -1);
      if (nb > 0 && cur != prv) close_word();
      if (cur >= 0) begin
        if (nb == 0) chk(s_cnt == 1, "R4 MSB slot", s_cnt, 1);
        acc = {acc[DW-2:0], (cur == 1) ? sd_r : sd_l};
        nb++;
      end
      prv = cur;
    end
  end

  // Driver: one half-frame of L bit periods with word select at level v.
  task automatic half(logic v, int L);
    @(negedge sck);
    ws = v;
    q.push_back('{data: val(k), nbits: 6'((L < DW) ? L : DW), src: v});
    repeat (4) @(negedge sck);
    if (v) begin
      smp_r = ~smp_r ^ 24'h5A5A5A;
      smp_l = val(k + 1);
    end else begin
      smp_l = ~smp_l ^ 24'h5A5A5A;
      smp_r = val(k + 1);
    end
    repeat (L - 5) @(negedge sck);
    k++;
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1;
    chk(!oe_l && !sd_l, "R1 left reset state", {oe_l, sd_l}, 0);
    chk(!oe_r && !sd_r, "R1 right reset state", {oe_r, sd_r}, 0);
    rst_n = 1'b1;
    smp_l = val(0);
    sck_run = 1'b1;
    repeat (6) @(negedge sck);
    #30;
    chk(!oe_l && !oe_r, "R1 idle before first ws edge", {oe_l, oe_r}, 0);
    half(1'b0, 32);
    half(1'b1, 32);
    half(1'b0, 32);
    half(1'b1, 32);
    half(1'b0, 12);
    half(1'b1, 32);
    half(1'b0, 32);
    half(1'b1, 20);
    half(1'b0, 32);
    half(1'b1, 8);
    half(1'b0, 32);
    half(1'b1, 32);
    repeat (40) @(negedge sck);
    chk(q.size() == 0, "R2 R3 all words delivered", q.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #300000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule